// File: doc/BRIEF.md
# Three-Wire Half-Duplex Register Master

This block is the host-side master for a sensor reached over a three-wire link. The three wires are a serial clock, one bidirectional data line and an active-low select. A host offers one request at a time. The block runs one of four operations: a single-register write, a single-register read, a motion burst read, or a select-only sync pulse. When the operation ends, the block raises a one-cycle completion strobe.

Every timing interval is derived from one parameter, the number of clock cycles per microsecond. A single shared data pin carries both directions. The block turns the pin around after the address byte, keeps the address-to-data spacing, and drops its output enable during every read phase and whenever it is idle. A burst read returns two signed 8-bit motion deltas. The block then releases select at once, which cuts the sensor's burst short.

Top module: `tw_reg_master`

## Requirements
- R1: After reset, and whenever no operation is running, `sel_n` is 1, `sclk` is 1, `sdata_oe` is 0, and `busy` and `done` are 0.
- R2: Each byte the master sends goes out most significant bit first. The bit is placed on `sdata_o` when `sclk` falls and holds for exactly 2 µs of low clock (2·CLKS_PER_US cycles). After that, `sclk` rises.
- R3: A write (`req_op` = 0) sends, inside one select window, the address byte with bit 7 set and `req_addr` in bits 6:0. The `req_wdata` byte follows it.
- R4: A read (`req_op` = 1) sends the address byte with bit 7 clear, then clocks in one byte MSB first. Each read bit has exactly 1 µs of low clock, the line is sampled at the end of that low time, and then the clock stays high for 1 µs. The byte appears on `rd_data` when `done` pulses.
- R5: After a byte is driven out, the clock stays high for at least 4 µs before the next falling clock edge or the release of select.
- R6: `sdata_oe` is 0 during every bit of a byte clocked in, and whenever `sel_n` is 1.
- R7: A burst (`req_op` = 2) sends address byte 0x63 and clocks in two bytes: first `burst_dx`, then `burst_dy`. Both are presented as signed two's-complement values.
- R8: On a read, select rises no sooner than 2 µs after the last rising clock edge. On a burst, select rises between 1 µs and 1 µs plus two cycles after the last rising clock edge, with no further clocks.
- R9: A sync (`req_op` = 3) drives `sel_n` low for exactly 1 µs with no clock edges.
- R10: `done` is a one-cycle pulse in the first cycle in which `sel_n` is back at 1. `busy` covers the operation. A request raised while `busy` is 1 is ignored and starts no select window.

Parameter: `CLKS_PER_US` (default 50).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 2 | 0 write, 1 read, 2 burst, 3 sync |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 8 | Byte from the last read |
| burst_dx | output | 8 | Signed first burst delta |
| burst_dy | output | 8 | Signed second burst delta |
| sclk | output | 1 | Serial clock, idles high |
| sdata_o | output | 1 | Data line output value |
| sdata_oe | output | 1 | Data line output enable |
| sdata_i | input | 1 | Data line input value |
| sel_n | output | 1 | Active-low select |

## Verification
A sensor model on the bench decodes every select window and keeps a register image, and a scoreboard checks each result against it.

The data patterns are chosen so each one exposes a different fault:
- Alternating bits (0x55, 0xAA) show a reversed bit order or a shift off by one bit.
- All-ones and all-zero addresses show a direction bit that is merged wrongly into the address.
- Burst deltas of 0x80/0x7F and 0xFF/0x01 show sign handling and dx/dy swaps.

The bench measures the duration of every clock phase and turnaround in cycles, so a wrong delay constant shows up even when the data is correct. A write raised during a running read, followed by a read-back of the targeted register, shows whether requests leak through while the block is busy.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 7;
    localparam int WR_LOW_US   = 2;
    localparam int RD_LOW_US   = 1;
    localparam int RD_HIGH_US  = 1;
    localparam int GAP_US      = 4;
    localparam int TAIL_US     = 1;
    localparam int SYNC_US     = 1;
    localparam int WR_HIGH_CYC = 1;
    localparam logic [ADDR_W-1:0] BURST_ADDR = 7'h63;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_BURST = 2'd2,
        OP_SYNC  = 2'd3
    } tw_op_e;

    typedef enum logic [1:0] {
        E_IDLE,
        E_LOW,
        E_HIGH
    } eng_state_e;

    typedef enum logic [3:0] {
        T_IDLE,
        T_ADDR,
        T_GAP1,
        T_WDATA,
        T_GAP2,
        T_RDATA,
        T_TAIL,
        T_DX,
        T_DY,
        T_SYNC
    } top_state_e;

    typedef struct packed {
        tw_op_e             op;
        logic [BYTE_W-1:0]  wdata;
    } req_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [BYTE_W-1:0] addr_byte(input tw_op_e op,
                                                    input logic [ADDR_W-1:0] a);
        case (op)
            OP_WRITE: addr_byte = {1'b1, a};
            OP_BURST: addr_byte = {1'b0, BURST_ADDR};
            default:  addr_byte = {1'b0, a};
        endcase
    endfunction

endpackage

// File: rtl/tw_delay.sv
module tw_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         fire
);
    logic [W-1:0] cnt;
    logic         active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (load) begin
            cnt    <= len - 1'b1;
            active <= 1'b1;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign fire = active && (cnt == '0);

    assert_len_valid_R5: assert property (@(posedge clk) disable iff (rst)
        load |-> (len != '0));

endmodule

// File: rtl/tw_byte_engine.sv
module tw_byte_engine
    import tw_pkg::*;
#(
    parameter int CLKS_PER_US = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr,
    input  logic [BYTE_W-1:0] tx,
    output logic              done,
    output logic [BYTE_W-1:0] rx,
    output logic              sclk,
    output logic              sdo,
    output logic              oe,
    input  logic              sdi
);
    localparam int WLO  = WR_LOW_US  * CLKS_PER_US;
    localparam int RLO  = RD_LOW_US  * CLKS_PER_US;
    localparam int RHI  = RD_HIGH_US * CLKS_PER_US;
    localparam int TW   = $clog2(max2(max2(WLO, RLO), RHI) + 1);
    localparam int BW   = $clog2(BYTE_W);
    localparam logic [TW-1:0] WLO_L = TW'(WLO);
    localparam logic [TW-1:0] RLO_L = TW'(RLO);
    localparam logic [TW-1:0] RHI_L = TW'(RHI);
    localparam logic [TW-1:0] WHI_L = TW'(WR_HIGH_CYC);
    localparam logic [BW-1:0] LAST  = BW'(BYTE_W - 1);

    eng_state_e        st;
    logic              wr_q;
    logic [BYTE_W-1:0] shreg;
    logic [BW-1:0]     nbit;
    logic              t_load;
    logic [TW-1:0]     t_len;
    logic              t_fire;

    tw_delay #(.W(TW)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .load (t_load),
        .len  (t_len),
        .fire (t_fire)
    );

    always_comb begin
        t_load = 1'b0;
        t_len  = WLO_L;
        case (st)
            E_IDLE: if (start) begin
                t_load = 1'b1;
                t_len  = wr ? WLO_L : RLO_L;
            end
            E_LOW: if (t_fire) begin
                t_load = 1'b1;
                t_len  = wr_q ? WHI_L : RHI_L;
            end
            E_HIGH: if (t_fire && nbit != LAST) begin
                t_load = 1'b1;
                t_len  = wr_q ? WLO_L : RLO_L;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= E_IDLE;
            wr_q  <= 1'b0;
            shreg <= '0;
            nbit  <= '0;
            sclk  <= 1'b1;
            oe    <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                E_IDLE: if (start) begin
                    shreg <= tx;
                    wr_q  <= wr;
                    oe    <= wr;
                    nbit  <= '0;
                    sclk  <= 1'b0;
                    st    <= E_LOW;
                end
                E_LOW: if (t_fire) begin
                    if (!wr_q) shreg <= {shreg[BYTE_W-2:0], sdi};
                    sclk <= 1'b1;
                    st   <= E_HIGH;
                end
                E_HIGH: if (t_fire) begin
                    if (nbit == LAST) begin
                        oe   <= 1'b0;
                        done <= 1'b1;
                        st   <= E_IDLE;
                    end else begin
                        nbit <= nbit + 1'b1;
                        if (wr_q) shreg <= {shreg[BYTE_W-2:0], 1'b0};
                        sclk <= 1'b0;
                        st   <= E_LOW;
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    assign sdo = shreg[BYTE_W-1];
    assign rx  = shreg;

    assert_idle_clock_high_R1: assert property (@(posedge clk) disable iff (rst)
        (st == E_IDLE) |-> (sclk && !oe));

    assert_data_held_at_rise_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(sclk) && oe) |-> $stable(sdo));

endmodule

// File: rtl/tw_reg_master.sv
module tw_reg_master
    import tw_pkg::*;
#(
    parameter int CLKS_PER_US = 50
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [6:0]          req_addr,
    input  logic [7:0]          req_wdata,
    output logic                busy,
    output logic                done,
    output logic [7:0]          rd_data,
    output logic signed [7:0]   burst_dx,
    output logic signed [7:0]   burst_dy,
    output logic                sclk,
    output logic                sdata_o,
    output logic                sdata_oe,
    input  logic                sdata_i,
    output logic                sel_n
);
    localparam int GAP_CYC  = GAP_US  * CLKS_PER_US;
    localparam int TAIL_CYC = TAIL_US * CLKS_PER_US;
    localparam int SYNC_CYC = SYNC_US * CLKS_PER_US;
    localparam int TW       = $clog2(max2(max2(GAP_CYC, TAIL_CYC), SYNC_CYC) + 1);
    localparam logic [TW-1:0] GAP_L  = TW'(GAP_CYC);
    localparam logic [TW-1:0] TAIL_L = TW'(TAIL_CYC);
    localparam logic [TW-1:0] SYNC_L = TW'(SYNC_CYC);

    top_state_e        st;
    req_t              rq;
    tw_op_e            in_op;
    logic              eng_start;
    logic              eng_wr;
    logic [BYTE_W-1:0] eng_tx;
    logic              eng_done;
    logic [BYTE_W-1:0] eng_rx;
    logic              t_load;
    logic [TW-1:0]     t_len;
    logic              t_fire;

    assign in_op = tw_op_e'(req_op);

    tw_byte_engine #(.CLKS_PER_US(CLKS_PER_US)) u_engine (
        .clk   (clk),
        .rst   (rst),
        .start (eng_start),
        .wr    (eng_wr),
        .tx    (eng_tx),
        .done  (eng_done),
        .rx    (eng_rx),
        .sclk  (sclk),
        .sdo   (sdata_o),
        .oe    (sdata_oe),
        .sdi   (sdata_i)
    );

    tw_delay #(.W(TW)) u_gap (
        .clk  (clk),
        .rst  (rst),
        .load (t_load),
        .len  (t_len),
        .fire (t_fire)
    );

    always_comb begin
        eng_start = 1'b0;
        eng_wr    = 1'b0;
        eng_tx    = '0;
        t_load    = 1'b0;
        t_len     = GAP_L;
        case (st)
            T_IDLE: if (req_valid) begin
                if (in_op == OP_SYNC) begin
                    t_load = 1'b1;
                    t_len  = SYNC_L;
                end else begin
                    eng_start = 1'b1;
                    eng_wr    = 1'b1;
                    eng_tx    = addr_byte(in_op, req_addr);
                end
            end
            T_ADDR, T_WDATA: if (eng_done) begin
                t_load = 1'b1;
                t_len  = GAP_L;
            end
            T_GAP1: if (t_fire) begin
                eng_start = 1'b1;
                eng_wr    = (rq.op == OP_WRITE);
                eng_tx    = rq.wdata;
            end
            T_RDATA: if (eng_done) begin
                t_load = 1'b1;
                t_len  = TAIL_L;
            end
            T_DX: if (eng_done) begin
                eng_start = 1'b1;
                eng_wr    = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= T_IDLE;
            rq       <= '{op: OP_WRITE, wdata: '0};
            sel_n    <= 1'b1;
            done     <= 1'b0;
            rd_data  <= '0;
            burst_dx <= '0;
            burst_dy <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                T_IDLE: if (req_valid) begin
                    rq    <= '{op: in_op, wdata: req_wdata};
                    sel_n <= 1'b0;
                    st    <= (in_op == OP_SYNC) ? T_SYNC : T_ADDR;
                end
                T_ADDR: if (eng_done) st <= T_GAP1;
                T_GAP1: if (t_fire) begin
                    case (rq.op)
                        OP_WRITE: st <= T_WDATA;
                        OP_READ:  st <= T_RDATA;
                        default:  st <= T_DX;
                    endcase
                end
                T_WDATA: if (eng_done) st <= T_GAP2;
                T_RDATA: if (eng_done) begin
                    rd_data <= eng_rx;
                    st      <= T_TAIL;
                end
                T_DX: if (eng_done) begin
                    burst_dx <= $signed(eng_rx);
                    st       <= T_DY;
                end
                T_DY: if (eng_done) begin
                    burst_dy <= $signed(eng_rx);
                    sel_n    <= 1'b1;
                    done     <= 1'b1;
                    st       <= T_IDLE;
                end
                T_GAP2, T_TAIL, T_SYNC: if (t_fire) begin
                    sel_n <= 1'b1;
                    done  <= 1'b1;
                    st    <= T_IDLE;
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    assign busy = (st != T_IDLE);

    assert_released_when_deselected_R6: assert property (@(posedge clk) disable iff (rst)
        sel_n |-> !sdata_oe);

    assert_no_drive_in_read_R4: assert property (@(posedge clk) disable iff (rst)
        (st == T_RDATA || st == T_DX || st == T_DY) |-> !sdata_oe);

    assert_sync_no_clock_R9: assert property (@(posedge clk) disable iff (rst)
        (st == T_SYNC) |-> sclk);

    assert_burst_release_R7: assert property (@(posedge clk) disable iff (rst)
        (st == T_DY && eng_done) |=> (sel_n && sclk));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_deselected_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (sel_n && !busy));

endmodule

// File: tb/test_tw_reg_master.sv
module test_tw_reg_master;
    localparam int US = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [6:0]  req_addr = 7'd0;
    logic [7:0]  req_wdata = 8'd0;
    logic        busy, done;
    logic [7:0]  rd_data;
    logic signed [7:0] burst_dx, burst_dy;
    logic        sclk, sdata_o, sdata_oe, sel_n;
    logic        sdata_i = 1'b0;

    tw_reg_master #(.CLKS_PER_US(US)) i_tw_reg_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .burst_dx(burst_dx), .burst_dy(burst_dy),
        .sclk(sclk), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
        .sdata_i(sdata_i), .sel_n(sel_n)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always @(negedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // sensor model
    logic [7:0] regs [128];
    logic [7:0] dx_v, dy_v, send, sh, cur_addr;
    logic [7:0] last_wa, last_wd;
    int ph = 0, nb = 0, t_fall = 0, t_rise = 0, t_sel = 0, edges = 0, sel_falls = 0;
    bit after_write = 1'b0;
    bit in_burst = 1'b0;
    int cur_op = 0;

    initial for (int i = 0; i < 128; i++) regs[i] = 8'((i * 37) ^ 8'h5A);

    always @(negedge sel_n) begin
        ph = 1; nb = 0; edges = 0; t_sel = cyc; sel_falls++; after_write = 1'b0;
    end

    always @(posedge sel_n) begin
        if (!rst) begin
            if (cur_op == 3) begin
                chk(cyc - t_sel == US, "R9 sync width", cyc - t_sel, US);
                chk(edges == 0, "R9 sync clock edges", edges, 0);
            end else if (cur_op == 1) begin
                chk(cyc - t_rise >= 2 * US, "R8 read select release", cyc - t_rise, 2 * US);
            end else if (cur_op == 2) begin
                chk(cyc - t_rise >= US && cyc - t_rise <= US + 2, "R8 burst select release",
                    cyc - t_rise, US + 1);
            end else if (cur_op == 0) begin
                chk(cyc - t_rise >= 4 * US, "R5 gap before deselect", cyc - t_rise, 4 * US);
            end
            ph = 0;
        end
    end

    always @(posedge sclk) begin
        if (!sel_n) begin
            edges++;
            if (ph == 1 || ph == 2) begin
                chk(sdata_oe == 1'b1, "R3 drive during write", int'(sdata_oe), 1);
                chk(cyc - t_fall == 2 * US, "R2 write low time", cyc - t_fall, 2 * US);
                sh = {sh[6:0], sdata_o};
                nb++;
                if (nb == 8) begin
                    nb = 0;
                    after_write = 1'b1;
                    if (ph == 1) begin
                        cur_addr = sh;
                        if (sh[7]) ph = 2;
                        else begin
                            ph = 3;
                            in_burst = (sh[6:0] == 7'h63);
                            send = in_burst ? dx_v : regs[sh[6:0]];
                        end
                    end else begin
                        regs[cur_addr[6:0]] = sh;
                        last_wa = cur_addr;
                        last_wd = sh;
                        ph = 0;
                    end
                end
            end else if (ph == 3) begin
                chk(sdata_oe == 1'b0, "R6 released during read bit", int'(sdata_oe), 0);
                chk(cyc - t_fall == US, "R4 read low time", cyc - t_fall, US);
                nb++;
                if (nb == 8) begin
                    nb = 0;
                    if (in_burst) begin send = dy_v; in_burst = 1'b0; end
                end
            end
            t_rise = cyc;
        end
    end

    always @(negedge sclk) begin
        if (!sel_n) begin
            edges++;
            if (after_write)
                chk(cyc - t_rise >= 4 * US, "R5 turnaround gap", cyc - t_rise, 4 * US);
            after_write = 1'b0;
            t_fall = cyc;
            if (ph == 3) sdata_i = send[7 - nb];
        end
    end

    // scoreboard
    logic [17:0] expq[$];
    int n_done = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (sel_n) begin
                checks++;
                if (sdata_oe) begin
                    errors++;
                    $display("FAIL R6 enable while deselected: actual 1 expected 0");
                end
            end
            if (done) begin
                logic [17:0] e;
                n_done++;
                chk(sel_n == 1'b1, "R10 done with select high", int'(sel_n), 1);
                if (expq.size() == 0) begin
                    chk(1'b0, "R10 unexpected done", 1, 0);
                end else begin
                    e = expq.pop_front();
                    case (e[17:16])
                        2'd0: chk({last_wa, last_wd} == e[15:0], "R3 write frame",
                                  int'({last_wa, last_wd}), int'(e[15:0]));
                        2'd1: chk(rd_data == e[7:0], "R4 read data", int'(rd_data), int'(e[7:0]));
                        2'd2: begin
                            chk(burst_dx == $signed(e[15:8]), "R7 burst dx",
                                int'(burst_dx), int'($signed(e[15:8])));
                            chk(burst_dy == $signed(e[7:0]), "R7 burst dy",
                                int'(burst_dy), int'($signed(e[7:0])));
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic run_op(input int op, input logic [6:0] a, input logic [7:0] wd,
                          input logic [15:0] exp, input bit poke);
        int target;
        @(negedge clk);
        while (busy) @(negedge clk);
        cur_op = op;
        expq.push_back({2'(op), exp});
        target = n_done + 1;
        req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            repeat (300) @(negedge clk);
            req_valid = 1'b1; req_op = 2'd0; req_addr = 7'h05; req_wdata = 8'hAA;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (n_done < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [7:0] r5;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sel_n == 1 && sclk == 1 && sdata_oe == 0 && busy == 0 && done == 0,
            "R1 reset state", int'({sel_n, sclk, sdata_oe, busy, done}), 5'b11000);
        run_op(1, 7'h00, 8'h00, {8'h00, regs[0]}, 1'b0);
        run_op(0, 7'h19, 8'h55, {8'h99, 8'h55}, 1'b0);
        run_op(1, 7'h19, 8'h00, 16'h0055, 1'b0);
        run_op(0, 7'h7F, 8'hAA, {8'hFF, 8'hAA}, 1'b0);
        run_op(1, 7'h7F, 8'h00, 16'h00AA, 1'b0);
        run_op(0, 7'h00, 8'hFF, {8'h80, 8'hFF}, 1'b0);
        run_op(1, 7'h00, 8'h00, 16'h00FF, 1'b0);
        dx_v = 8'h80; dy_v = 8'h7F;
        run_op(2, 7'h11, 8'h00, 16'h807F, 1'b0);
        dx_v = 8'hFF; dy_v = 8'h01;
        run_op(2, 7'h00, 8'h00, 16'hFF01, 1'b0);
        run_op(3, 7'h00, 8'h00, 16'h0000, 1'b0);
        r5 = regs[5];
        run_op(1, 7'h22, 8'h00, {8'h00, regs[8'h22]}, 1'b1);
        run_op(1, 7'h05, 8'h00, {8'h00, r5}, 1'b0);
        chk(sel_falls == 12, "R10 select windows", sel_falls, 12);
        chk(busy == 0 && sel_n == 1 && sclk == 1, "R1 idle after ops",
            int'({busy, sel_n, sclk}), 3'b011);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule